// File: doc/BRIEF.md
# Burst Serial Register Access Sequencer

This block is the slave side of a byte-oriented serial control port framed by an active-low chip select. Bits arrive MSB first, one per cycle in which the bit strobe is high. The first complete byte after chip select falls is a command. It carries a read/write flag, a selector between per-channel (local) and shared (global) register files, and a 5-bit register address. Every later byte in the frame is data. The two low bits of the address set the burst length. The block then walks down through adjacent addresses, from the addressed register to the one whose low bits are 00, and reads or writes one register per data byte.

Local registers are replicated once per channel. A channel-enable mask that is set up before the frame picks the channels. A write lands in every enabled channel at once. A read returns the lowest-numbered enabled channel. The global file implements 27 registers, and the remaining addresses in its space are holes. Raising chip select at any point drops the byte in progress and the rest of the burst. Bytes already finished keep their effect.

Top module: `serreg_seq`

## Requirements
- R1: Command byte layout: bit 7 = 1 read / 0 write, bit 6 = 1 local / 0 global, bit 5 ignored, bits 4:0 register address; only the first full byte after chip select falls is decoded as a command.
- R2: Address bits 1:0 set the burst length: 00 gives 1 register, 01 gives 2, 10 gives 3, 11 gives 4.
- R3: Data byte k (k = 0 first) of a burst addresses register (address − k), so the highest address is handled first; bytes past the burst have no effect and read as zero.
- R4: Chip select high aborts the burst: the partially received byte and all remaining registers are dropped, while registers whose byte already completed keep their new values.
- R5: A further command is only accepted after chip select goes high and low again; extra bytes within a frame are never taken as a command.
- R6: A local write updates register (address − k) in every channel i whose chan_en[i] is 1, and leaves channels with chan_en[i] = 0 unchanged.
- R7: A local read returns the lowest-numbered enabled channel; with no channel enabled it returns 0x00.
- R8: Global addresses 0–25 and 28 are implemented; writes to 26, 27, 29, 30 and 31 are ignored and reads of them return 0x00.
- R9: Serial data is MSB first; a write is committed only when the eighth bit of its data byte has been clocked in.
- R10: During a read burst, sdo presents the addressed register MSB first across the data byte, each bit valid before the strobe edge that takes the matching input bit; sdo is 0 during the command byte, during write frames and while chip select is high.
- R11: After reset every register reads 0x00 and sdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csn | input | 1 | Active-low frame select |
| bit_en | input | 1 | Serial bit strobe: one bit is taken on each clock edge where it is high |
| sdi | input | 1 | Serial data in, MSB first |
| chan_en | input | NCH | Channel-enable mask for local accesses, bit i = channel i |
| sdo | output | 1 | Serial read data out, MSB first |

## Verification
Writes are observed through the port's own read path in later frames. A write therefore becomes visible one frame after its eighth data bit, and the bench checks it by reading the register back. For a read, the byte due on sdo is loaded at the clock edge that takes the final bit of the previous byte. The bench samples sdo on the falling edge before each strobe edge, so the first sample of a data byte already shows its MSB. After chip select rises, sdo must be zero from the next edge onward, and the bench checks it two falling edges later.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int REM_W  = 3;
  localparam int GLB_LAST_DENSE = 25;
  localparam int GLB_EXTRA      = 28;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [REM_W-1:0]  rem_t;

  function automatic logic glb_valid(addr_t a);
    return (int'(a) <= GLB_LAST_DENSE) || (int'(a) == GLB_EXTRA);
  endfunction
endpackage

// File: rtl/serreg_shift.sv
module serreg_shift
  import serreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  csn,
  input  logic  bit_en,
  input  logic  sdi,
  input  logic  load_en,
  input  byte_t load_val,
  output logic  byte_done,
  output byte_t byte_val,
  output logic  sdo
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-2:0] rx_q, rx_d;
  byte_t             tx_q, tx_d;

  assign byte_done = !csn && bit_en && (cnt_q == LAST);
  assign byte_val  = {rx_q, sdi};
  assign sdo       = tx_q[BYTE_W-1];

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (csn) begin
      cnt_d = '0;
      rx_d  = '0;
      tx_d  = '0;
    end else if (bit_en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      rx_d  = {rx_q[BYTE_W-3:0], sdi};
      if (byte_done) tx_d = load_en ? load_val : '0;
      else           tx_d = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end
endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
  import serreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  csn,
  input  logic  byte_done,
  input  logic  cmd_rd,
  input  logic  cmd_loc,
  input  addr_t cmd_addr,
  output logic  have_cmd,
  output logic  loc_q,
  output addr_t addr_q,
  output rem_t  rem_q,
  output logic  wr_en,
  output logic  rd_load,
  output addr_t rd_addr,
  output logic  rd_loc
);
  logic  have_d, rd_q, rd_d, loc_d;
  addr_t addr_d;
  rem_t  rem_d;
  logic  have_q;

  assign have_cmd = have_q;

  always_comb begin
    have_d = have_q;
    rd_d   = rd_q;
    loc_d  = loc_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (csn) begin
      have_d = 1'b0;
      rem_d  = '0;
    end else if (byte_done) begin
      if (!have_q) begin
        have_d = 1'b1;
        rd_d   = cmd_rd;
        loc_d  = cmd_loc;
        addr_d = cmd_addr;
        rem_d  = rem_t'(cmd_addr[1:0]) + 1'b1;
      end else if (rem_q != '0) begin
        rem_d  = rem_q - 1'b1;
        addr_d = addr_q - 1'b1;
      end
    end
  end

  assign wr_en   = byte_done && have_q && !rd_q && (rem_q != '0);
  assign rd_load = byte_done && (have_q ? (rd_q && (rem_q > rem_t'(1))) : cmd_rd);
  assign rd_addr = have_q ? (addr_q - 1'b1) : cmd_addr;
  assign rd_loc  = have_q ? loc_q : cmd_loc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      rd_q   <= 1'b0;
      loc_q  <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      have_q <= have_d;
      rd_q   <= rd_d;
      loc_q  <= loc_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/serreg_lfile.sv
module serreg_lfile
  import serreg_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic           wen,
  input  addr_t          waddr,
  input  byte_t          wdata,
  input  addr_t          raddr,
  output byte_t          rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t chrd [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    byte_t mem [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wen && chan_en[c]) begin
        mem[waddr] <= wdata;
      end
    end
    assign chrd[c] = mem[raddr];
  end

  always_comb begin
    rdata = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (chan_en[c]) rdata = chrd[c];
    end
  end
endmodule

// File: rtl/serreg_gfile.sv
module serreg_gfile
  import serreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wen,
  input  addr_t waddr,
  input  byte_t wdata,
  input  addr_t raddr,
  output byte_t rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (glb_valid(addr_t'(i))) begin : g_live
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= '0;
        else if (wen && waddr == addr_t'(i))  q <= wdata;
      end
      assign ent[i] = q;
    end else begin : g_hole
      assign ent[i] = '0;
    end
  end

  assign rdata = ent[raddr];
endmodule

// File: rtl/serreg_seq.sv
module serreg_seq
  import serreg_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csn,
  input  logic           bit_en,
  input  logic           sdi,
  input  logic [NCH-1:0] chan_en,
  output logic           sdo
);
  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic  byte_done, have_cmd, loc_q, wr_en, rd_load, rd_loc;
  byte_t byte_val, rd_data, lrd, grd;
  addr_t addr_q, rd_addr;
  rem_t  rem_q;

  serreg_shift u_shift (
    .clk(clk), .rst_n(rst_ns), .csn(csn), .bit_en(bit_en), .sdi(sdi),
    .load_en(rd_load), .load_val(rd_data),
    .byte_done(byte_done), .byte_val(byte_val), .sdo(sdo)
  );

  serreg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_ns), .csn(csn), .byte_done(byte_done),
    .cmd_rd(byte_val[7]), .cmd_loc(byte_val[6]), .cmd_addr(byte_val[ADDR_W-1:0]),
    .have_cmd(have_cmd), .loc_q(loc_q), .addr_q(addr_q), .rem_q(rem_q),
    .wr_en(wr_en), .rd_load(rd_load), .rd_addr(rd_addr), .rd_loc(rd_loc)
  );

  serreg_lfile #(.NCH(NCH)) u_lfile (
    .clk(clk), .rst_n(rst_ns), .chan_en(chan_en),
    .wen(wr_en && loc_q), .waddr(addr_q), .wdata(byte_val),
    .raddr(rd_addr), .rdata(lrd)
  );

  serreg_gfile u_gfile (
    .clk(clk), .rst_n(rst_ns),
    .wen(wr_en && !loc_q), .waddr(addr_q), .wdata(byte_val),
    .raddr(rd_addr), .rdata(grd)
  );

  assign rd_data = rd_loc ? lrd : grd;
endmodule

// File: rtl/serreg_chk.sv
module serreg_chk
  import serreg_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  csn,
  input logic  sdo,
  input logic  have_cmd,
  input rem_t  rem,
  input addr_t addr,
  input logic  wr_en,
  input logic  rd_loc,
  input addr_t rd_addr,
  input byte_t rd_data
);
  a_r5_csn_drops_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> !have_cmd);

  a_r4_csn_drops_burst: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> (rem == '0));

  a_r10_sdo_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> !sdo);

  a_r10_sdo_quiet_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !have_cmd |-> !sdo);

  a_r2_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= rem_t'(4));

  a_r2_burst_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(have_cmd) |-> (rem != '0));

  a_r3_descend: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rem > rem_t'(1)) |=> (addr == $past(addr) - 1'b1));

  a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_loc && !glb_valid(rd_addr)) |-> (rd_data == '0));
endmodule

bind serreg_seq serreg_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .csn(csn), .sdo(sdo), .have_cmd(have_cmd),
  .rem(rem_q), .addr(addr_q), .wr_en(wr_en), .rd_loc(rd_loc),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/serreg_seq_bench.sv
module serreg_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n, csn, bit_en, sdi, sdo;
  logic [NCH-1:0] chan_en;

  serreg_seq #(.NCH(NCH)) u_serreg_seq (
    .clk(clk), .rst_n(rst_n), .csn(csn), .bit_en(bit_en), .sdi(sdi),
    .chan_en(chan_en), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit gap = 1'b0;
  logic [7:0] lm [NCH][32];
  logic [7:0] gm [32];
  logic [7:0] wq [$];

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic bit gvalid(int a);
    return (a <= 25) || (a == 28);
  endfunction

  function automatic logic [7:0] model_rd(bit loc, int a);
    if (loc) begin
      for (int c = 0; c < NCH; c++) if (chan_en[c]) return lm[c][a];
      return 8'h00;
    end
    return gvalid(a) ? gm[a] : 8'h00;
  endfunction

  task automatic model_wr(bit loc, int a, logic [7:0] d);
    if (loc) begin
      for (int c = 0; c < NCH; c++) if (chan_en[c]) lm[c][a] = d;
    end else if (gvalid(a)) begin
      gm[a] = d;
    end
  endtask

  task automatic xbit(logic b, output logic so);
    if (gap) begin
      @(negedge clk);
      bit_en = 1'b0;
    end
    @(negedge clk);
    so = sdo;
    sdi = b;
    bit_en = 1'b1;
  endtask

  task automatic xbyte(logic [7:0] b, output logic [7:0] got);
    logic so;
    for (int i = 7; i >= 0; i--) begin
      xbit(b[i], so);
      got[i] = so;
    end
  endtask

  task automatic end_frame(string tag);
    @(negedge clk);
    bit_en = 1'b0;
    csn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R10 sdo idle"}, {7'd0, sdo}, 8'h00);
  endtask

  // Full frame: command, ndata bytes from wq (zeros for reads), then cut extra bits.
  task automatic frame(logic [7:0] cmd, int ndata, int cut, string tag);
    logic [7:0] got, exp, d;
    logic so;
    bit rd, loc;
    int a, burst;
    rd = cmd[7]; loc = cmd[6]; a = int'(cmd[4:0]); burst = int'(cmd[1:0]) + 1;
    @(negedge clk);
    csn = 1'b0;
    xbyte(cmd, got);
    chk({tag, " R10 sdo during command"}, got, 8'h00);
    for (int k = 0; k < ndata; k++) begin
      d = (!rd && wq.size() > 0) ? wq.pop_front() : 8'h00;
      xbyte(d, got);
      exp = (rd && k < burst) ? model_rd(loc, (a - k) & 31) : 8'h00;
      chk($sformatf("%s R3 R10 byte %0d", tag, k), got, exp);
      if (!rd && k < burst) model_wr(loc, (a - k) & 31, d);
    end
    for (int i = 0; i < cut; i++) xbit(1'b1, so);
    wq.delete();
    end_frame(tag);
  endtask

  task automatic cmd_partial(logic [7:0] cmd, int nbits);
    logic so;
    @(negedge clk);
    csn = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) xbit(cmd[i], so);
    end_frame("R5 partial command");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) for (int a = 0; a < 32; a++) lm[c][a] = 8'h00;
    for (int a = 0; a < 32; a++) gm[a] = 8'h00;
    rst_n = 1'b0; csn = 1'b1; bit_en = 1'b0; sdi = 1'b0; chan_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 sdo after reset", {7'd0, sdo}, 8'h00);

    // R11: reset contents read zero
    chan_en = 8'h01;
    frame(8'hC3, 4, 0, "R11 local reset read");
    frame(8'h9F, 4, 0, "R11 global reset read");

    // R1 R2 R3: global burst of 4 (spare bit 5 set), read back
    wq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    frame(8'h27, 4, 0, "R1 global write 7..4");
    frame(8'h87, 4, 0, "R2 read 7..4");
    frame(8'h85, 2, 0, "R2 read 5..4");
    frame(8'h86, 5, 0, "R3 read 6..4 plus extra");

    // R5: burst of 1 with extra bytes, one shaped like a read command
    wq = '{8'h5A, 8'h87, 8'h00};
    frame(8'h08, 3, 0, "R5 write 8 plus extras");
    frame(8'h8B, 4, 0, "R5 read 11..8");

    // R8: reserved holes
    wq = '{8'h11, 8'h22, 8'h33, 8'h44};
    frame(8'h1B, 4, 0, "R8 write 27..24");
    frame(8'h9B, 4, 0, "R8 read 27..24");
    wq = '{8'h55, 8'h66, 8'h77, 8'h88};
    frame(8'h1F, 4, 0, "R8 write 31..28");
    frame(8'h9F, 4, 0, "R8 read 31..28");

    // R6 R7: local multi-channel
    chan_en = 8'b0010_0100;
    wq = '{8'h3C, 8'h4D, 8'h5E};
    frame(8'h42, 3, 0, "R6 local write ch2 ch5");
    chan_en = 8'b0000_0100;
    frame(8'hC2, 3, 0, "R6 read ch2");
    chan_en = 8'b0010_0000;
    frame(8'hC2, 3, 0, "R6 read ch5");
    chan_en = 8'b0000_0001;
    frame(8'hC2, 3, 0, "R6 read ch0 untouched");
    chan_en = 8'b1010_0000;
    frame(8'hC2, 3, 0, "R7 lowest enabled ch5");
    chan_en = 8'b0000_0000;
    frame(8'hC2, 3, 0, "R7 none enabled");
    chan_en = 8'b0000_0001;
    wq = '{8'h99};
    frame(8'h40, 1, 0, "R6 local write ch0 addr0");
    chan_en = 8'b0010_0101;
    frame(8'hC1, 2, 0, "R7 lowest ch0 of three");

    // R4 R9: abort mid-burst after 2 full bytes and 5 bits
    wq = '{8'hE1, 8'hE2, 8'hE3, 8'hE4};
    frame(8'h13, 2, 5, "R4 write abort");
    frame(8'h93, 4, 0, "R4 R9 read 19..16");

    // R4 R5: abort a read, then a fresh command
    frame(8'h93, 1, 3, "R4 read abort");
    cmd_partial(8'h07, 4);
    frame(8'h92, 3, 0, "R5 read after aborts");

    // R9: strobe with idle cycles between bits
    gap = 1'b1;
    wq = '{8'h6B, 8'h7C};
    frame(8'h01, 2, 0, "R9 gapped write 1..0");
    frame(8'h83, 4, 0, "R9 gapped read 3..0");
    gap = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule